// File: doc/BRIEF.md
# Serial Port Modem Handshake Registers

This block is the handshake half of a serial port. The host writes a control register whose two lowest bits drive two active-low outputs. One output tells the far end that the terminal is ready. The other is the request to send. The block also watches four active-low inputs from the line equipment: clear to send, data set ready, carrier detect and ring indicator. Each input passes through a multi-flop synchronizer. The synchronized levels are shown inverted in the top nibble of a status register. The low nibble holds sticky change flags.

Reading the status register returns the current value and clears the change flags. A change that arrives in the same cycle as the read is not lost: its flag is set again. The ring flag is set only when the ring input returns to its inactive high level. When the external enable is on, an interrupt output stays high while any change flag is set. A loop-mode input forces both handshake outputs inactive while it is high. The stored control bits are not altered. Register access uses plain read and write strobes with a one-bit register select.

Top module: `uart_modem_ctl`

## Requirements
- R1: Status bit 4 reads as the inverse of the synchronized `cts_n`, and status bit 5 as the inverse of the synchronized `dsr_n`. An input change is visible in the status register two clock edges after it is sampled.
- R2: Status bit 7 reads as the inverse of the synchronized `dcd_n`, and status bit 6 as the inverse of the synchronized `ri_n`.
- R3: Status bit 0 is set by any level change of `cts_n`, bit 1 by any level change of `dsr_n`, and bit 3 by any level change of `dcd_n`. Each flag stays set until the status register is read.
- R4: Status bit 2 is set only when `ri_n` goes from low to high. A high-to-low change of `ri_n` leaves it clear.
- R5: Writing the control register (`addr`=0) with bit 0 at 1 drives `dtr_n` low, and with bit 1 at 1 drives `rts_n` low. Writing either bit as 0 returns its output high.
- R6: After reset, `dtr_n` and `rts_n` are high, the control register reads 0, and the status change flags read 0.
- R7: While `loop_mode` is high, `dtr_n` and `rts_n` are both high. When `loop_mode` drops, they follow the stored control bits again.
- R8: `irq` is high exactly when `msi_en` is high and any of status bits 0 to 3 is set.
- R9: A status read (`rd_en` with `addr`=1) returns the flags and clears bits 0 to 3 at that clock edge, which drops `irq`.
- R10: A monitored change detected in the same cycle as a status read leaves its flag set after the read.
- R11: Control bits 7 to 2 are plain storage, and the whole control register reads back as written.
- R12: Level changes on `cts_n` and `dsr_n` have no effect on `dtr_n` or `rts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a status read clears the flags |
| addr | input | 1 | Register select: 0 control, 1 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| loop_mode | input | 1 | Loop mode; forces the handshake outputs inactive |
| msi_en | input | 1 | Modem status interrupt enable |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Modem status interrupt |

## Verification
A status read and a newly detected input change can land in the same clock edge. The clear then competes with the set of the same flag. The bench provokes this directly. It toggles `cts_n`, waits exactly the synchronizer delay, and raises the read strobe in the cycle where the change is detected. It then checks that this read shows the new level with the flag still clear, and that the following read shows the flag set.

A write to the control register can also meet a loop-mode change. The bench judges that case by comparing the outputs with `loop_mode` and the stored bits after every random step.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } mdm_sel_e;

   localparam int LINES = 4;

   // Line order inside every 4-bit vector; it is also the order of the
   // change flags (status bits 3:0) and of the levels (status bits 7:4).
   localparam int L_CTS = 0;
   localparam int L_DSR = 1;
   localparam int L_RI  = 2;
   localparam int L_DCD = 3;

   // Lines whose flag reacts only to a return to the inactive level
   localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_n,
   output logic [W-1:0] sync_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe[s] <= '1;
         end else if (s == 0) begin
            pipe[s] <= async_n;
         end else begin
            pipe[s] <= pipe[s-1];
         end
      end
   end

   assign sync_n = pipe[STAGES-1];
endmodule

// File: rtl/mdm_edge.sv
module mdm_edge #(
   parameter int             W    = 4,
   parameter logic [W-1:0]   MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur_n,
   output logic [W-1:0] prev_n,
   output logic [W-1:0] chg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= '1;
      end else begin
         prev_n <= cur_n;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      if (MASK[i]) begin : g_trail
         assign chg[i] = cur_n[i] & ~prev_n[i];
      end else begin : g_any
         assign chg[i] = cur_n[i] ^ prev_n[i];
      end
   end
endmodule

// File: rtl/mdm_flags.sv
module mdm_flags #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] chg,
   output logic [W-1:0] flags
);
   logic [W-1:0] kept;

   // A set in the clearing cycle wins over the clear
   assign kept = clr ? '0 : flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= kept | chg;
      end
   end
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic          loop_mode,
   output logic [DW-1:0] ctrl,
   output logic          dtr_n,
   output logic          rts_n
);
   localparam int B_DTR = 0;
   localparam int B_RTS = 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (we) begin
         ctrl <= wdata;
      end
   end

   assign dtr_n = loop_mode | ~ctrl[B_DTR];
   assign rts_n = loop_mode | ~ctrl[B_RTS];
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
   import mdm_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NSYNC  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          loop_mode,
   input  logic          msi_en,
   input  logic          cts_n,
   input  logic          dsr_n,
   input  logic          dcd_n,
   input  logic          ri_n,
   output logic          dtr_n,
   output logic          rts_n,
   output logic          irq
);
   localparam int SW = 2 * LINES;

   if (DW < SW) begin : g_bad_dw
      $error("uart_modem_ctl: DW must be at least 8");
   end

   logic [LINES-1:0] raw_n, sync_n, prev_n, chg, flags_q;
   logic [DW-1:0]    ctrl_q;
   logic [SW-1:0]    stat;
   logic             ctrl_we, stat_rd;

   assign raw_n[L_CTS] = cts_n;
   assign raw_n[L_DSR] = dsr_n;
   assign raw_n[L_RI]  = ri_n;
   assign raw_n[L_DCD] = dcd_n;

   assign ctrl_we = wr_en & (mdm_sel_e'(addr) == SEL_CTRL);
   assign stat_rd = rd_en & (mdm_sel_e'(addr) == SEL_STAT);

   mdm_sync #(.W(LINES), .STAGES(NSYNC)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (raw_n),
      .sync_n  (sync_n)
   );

   mdm_edge #(.W(LINES), .MASK(TRAIL_ONLY)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_n  (sync_n),
      .prev_n (prev_n),
      .chg    (chg)
   );

   mdm_flags #(.W(LINES)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stat_rd),
      .chg   (chg),
      .flags (flags_q)
   );

   mdm_ctrl #(.DW(DW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (ctrl_we),
      .wdata     (wdata),
      .loop_mode (loop_mode),
      .ctrl      (ctrl_q),
      .dtr_n     (dtr_n),
      .rts_n     (rts_n)
   );

   assign stat = {~sync_n, flags_q};

   always_comb begin
      rdata = '0;
      if (mdm_sel_e'(addr) == SEL_STAT) begin
         rdata[SW-1:0] = stat;
      end else begin
         rdata = ctrl_q;
      end
   end

   assign irq = msi_en & (|flags_q);
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic          addr,
   input logic [DW-1:0] wdata,
   input logic          loop_mode,
   input logic          msi_en,
   input logic          dtr_n,
   input logic          rts_n,
   input logic          irq,
   input logic [3:0]    chg,
   input logic [3:0]    flags,
   input logic [3:0]    sync_n,
   input logic [3:0]    prev_n
);
   // R7
   loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loop_mode |-> (dtr_n && rts_n));

   // R5
   dtr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[0]) |=> (loop_mode || !dtr_n));

   // R5
   rts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[1]) |=> (loop_mode || !rts_n));

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (msi_en && flags != 4'b0000));

   // R9
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr && chg == 4'b0000) |=> (flags == 4'b0000));

   // R10
   keep_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr && chg[0]) |=> flags[0]);

   // R4
   ring_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[2]) |-> ($past(sync_n[2]) && !$past(prev_n[2])));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .wdata     (wdata),
   .loop_mode (loop_mode),
   .msi_en    (msi_en),
   .dtr_n     (dtr_n),
   .rts_n     (rts_n),
   .irq       (irq),
   .chg       (chg),
   .flags     (flags_q),
   .sync_n    (sync_n),
   .prev_n    (prev_n)
);

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       loop_mode = 1'b0, msi_en = 1'b0;
   logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
   logic       dtr_n, rts_n, irq;

   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;
   logic [3:0] lines_n = 4'hF;   // {dcd, ri, dsr, cts}
   logic [3:0] exp_fl = 4'h0;
   logic [7:0] ctrl_m = 8'h00;

   always #4 clk = ~clk;

   uart_modem_ctl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .loop_mode(loop_mode), .msi_en(msi_en),
      .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
      .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
   );

   function automatic logic [3:0] flag_hits(logic [3:0] o, logic [3:0] n);
      logic [3:0] h;
      h    = o ^ n;
      h[2] = ~o[2] & n[2];
      return h;
   endfunction

   function automatic logic [7:0] exp_stat(logic [3:0] l, logic [3:0] f);
      return {~l, f};
   endfunction

   task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_lines(logic [3:0] v);
      @(negedge clk);
      exp_fl |= flag_hits(lines_n, v);
      lines_n = v;
      {dcd_n, ri_n, dsr_n, cts_n} = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_outs(string req);
      check(dtr_n == (loop_mode | ~ctrl_m[0]), req, {7'd0, dtr_n},
            {7'd0, loop_mode | ~ctrl_m[0]});
      check(rts_n == (loop_mode | ~ctrl_m[1]), req, {7'd0, rts_n},
            {7'd0, loop_mode | ~ctrl_m[1]});
   endtask

   task automatic read_stat(string req);
      @(negedge clk);
      rd_en = 1'b1; addr = 1'b1;
      #1;
      check(rdata == exp_stat(lines_n, exp_fl), req, rdata,
            exp_stat(lines_n, exp_fl));
      check(irq == (msi_en & |exp_fl), "R8", {7'd0, irq},
            {7'd0, msi_en & |exp_fl});
      @(negedge clk);
      rd_en = 1'b0;
      exp_fl = 4'h0;
      check(irq == 1'b0, "R9", {7'd0, irq}, 8'h00);
   endtask

   task automatic write_ctrl(logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; addr = 1'b0; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
      ctrl_m = v;
   endtask

   task automatic read_ctrl(string req);
      @(negedge clk);
      addr = 1'b0;
      #1;
      check(rdata == ctrl_m, req, rdata, ctrl_m);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R6 reset state
      @(negedge clk);
      check(dtr_n && rts_n, "R6", {6'd0, dtr_n, rts_n}, 8'h03);
      read_ctrl("R6");
      read_stat("R6");

      // R5 / R11 control writes and readback
      write_ctrl(8'h01); check_outs("R5");
      write_ctrl(8'h02); check_outs("R5");
      write_ctrl(8'hFF); check_outs("R5"); read_ctrl("R11");
      write_ctrl(8'hA4); check_outs("R5"); read_ctrl("R11");
      write_ctrl(8'h03);

      // R7 loop mode holds outputs, then releases
      @(negedge clk); loop_mode = 1'b1;
      #1 check_outs("R7");
      write_ctrl(8'h03); check_outs("R7");
      @(negedge clk); loop_mode = 1'b0;
      #1 check_outs("R7");

      // R12 cts/dsr toggles leave outputs alone; R1 / R3 flags and levels
      msi_en = 1'b1;
      drive_lines(4'b1110); check_outs("R12");
      drive_lines(4'b1100); check_outs("R12");
      read_stat("R1");
      drive_lines(4'b1111); check_outs("R12");
      read_stat("R3");

      // R2 / R4 ring trailing edge only, carrier change
      drive_lines(4'b1011);
      read_stat("R4");
      drive_lines(4'b1111);
      read_stat("R4");
      drive_lines(4'b0111);
      read_stat("R2");
      drive_lines(4'b1111);
      msi_en = 1'b0;
      #1 check(irq == 1'b0, "R8", {7'd0, irq}, 8'h00);
      read_stat("R3");
      msi_en = 1'b1;

      // R10 change detected in the very cycle of a status read
      @(negedge clk);
      cts_n = 1'b0; lines_n[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rd_en = 1'b1; addr = 1'b1;
      #1 check(rdata == exp_stat(lines_n, 4'h0), "R10", rdata,
               exp_stat(lines_n, 4'h0));
      @(negedge clk);
      rd_en = 1'b0;
      exp_fl = 4'b0001;
      #1 check(irq == 1'b1, "R10", {7'd0, irq}, 8'h01);
      read_stat("R10");

      // random mix
      for (int it = 0; it < 60; it++) begin
         case ($urandom % 4)
            0: drive_lines(4'($urandom));
            1: begin write_ctrl(8'($urandom)); read_ctrl("R11"); end
            2: read_stat("R3");
            default: begin
               @(negedge clk);
               loop_mode = 1'($urandom);
               msi_en = 1'($urandom);
               #1 check(irq == (msi_en & |exp_fl), "R8", {7'd0, irq},
                        {7'd0, msi_en & |exp_fl});
            end
         endcase
         #1 check_outs("R7");
      end
      read_stat("R9");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule